// File: doc/BRIEF.md
# Byte-Level Scratchpad Memory Function Decoder

This block is the memory-function layer of a single-wire bus slave. It runs once the device has already been selected on the bus. It receives bytes from the bit-level engine and interprets the first byte after selection as a function code. The next two bytes form a 16-bit target address, sent low byte first. The function codes write a 32-byte scratchpad, read it back, commit it to a 32-byte nonvolatile block, or reload the scratchpad from that block.

A commit follows three steps. The host first writes the scratchpad. It then reads the scratchpad back to confirm the contents. Last, it sends the commit code with the same address and one confirming byte, which must equal the page offset of the last scratchpad byte written. The nonvolatile store is modelled as a register array. Its write time is a parameter, counted in clock cycles. While that time runs, the block reports busy and protects its state. A bus reset from the bit-level engine abandons any function in progress at any point.

Top module: `ow_mem_decoder`

## Requirements
- R1: Function codes are 0x6C (write scratchpad), 0x69 (read scratchpad), 0x48 (commit) and 0xB8 (reload). Each code is followed by an address, low byte first. Only addresses 0x0020 to 0x003F are accepted, and the page offset is address & 0x1F. A function with any other address is ignored until the next bus reset, and tx_byte_o stays 0xFF.
- R2: After a write-scratchpad header, each received byte is stored at the current offset. The offset then advances by one and wraps from 31 to 0.
- R3: After a read-scratchpad header, tx_byte_o shows the scratchpad byte at the current offset. Each tx_req_i cycle advances the offset, wrapping from 31 to 0. Outside a read, tx_byte_o is 0xFF.
- R4: After a commit header, a fourth byte equal to the offset of the last scratchpad byte written copies all 32 scratchpad bytes into the nonvolatile block. busy_o then stays high for exactly BUSY_CYCLES cycles, starting with the cycle after that byte.
- R5: A commit whose fourth byte does not match leaves the nonvolatile block unchanged and does not raise busy_o.
- R6: While busy_o is high, tx_byte_o reads 0xFF, and the write-scratchpad, commit and reload functions have no effect.
- R7: A reload function with a valid address copies the whole nonvolatile block into the scratchpad when its address high byte arrives.
- R8: bus_reset_i high returns the decoder to waiting for a function code. Partial address bytes and any function in progress are discarded, and tx_byte_o is 0xFF in the next cycle.
- R9: An unrecognised function code causes every following byte to be ignored until a bus reset.
- R10: After rst_ni, the scratchpad and nonvolatile block are all zero, busy_o is low and tx_byte_o is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | Bus reset seen on the wire; aborts the current function |
| rx_valid_i | input | 1 | One-cycle strobe: rx_byte_i holds a received byte |
| rx_byte_i | input | 8 | Received byte |
| tx_req_i | input | 1 | One-cycle strobe: the host consumed tx_byte_o |
| tx_byte_o | output | 8 | Byte to transmit |
| busy_o | output | 1 | Nonvolatile write in progress |

## Verification
The assertions assume three things about the inputs. rx_valid_i and tx_req_i are single-cycle strobes. No byte arrives in the same cycle as a bus reset. The host never issues a second commit while busy_o is high, and the design refuses such a commit in any case. The stimulus meets these by driving every strobe for exactly one cycle from tasks aligned to the falling edge, and by sending a bus reset only between byte transfers. The busy window is measured by counting busy_o cycles, and the nonvolatile contents are observed only through a reload followed by a scratchpad read.

// File: rtl/ow_mem_pkg.sv
package ow_mem_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_ADL, ST_ADH, ST_WR, ST_RD, ST_END, ST_SINK
  } mem_state_e;

  localparam logic [7:0] FN_WRITE_SP  = 8'h6C;
  localparam logic [7:0] FN_READ_SP   = 8'h69;
  localparam logic [7:0] FN_COMMIT    = 8'h48;
  localparam logic [7:0] FN_RELOAD    = 8'hB8;
endpackage

// File: rtl/ow_mem_fsm.sv
module ow_mem_fsm
  import ow_mem_pkg::*;
#(
  parameter int          PAGE_BYTES = 32,
  parameter logic [15:0] BLOCK_BASE = 16'h0020,
  localparam int         OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             tx_req_i,
  input  logic             busy_i,
  output logic             sp_we_o,
  output logic [OFF_W-1:0] ptr_o,
  output logic             rd_active_o,
  output logic             reload_o,
  output logic             commit_o
);
  mem_state_e       state_q;
  logic [7:0]       cmd_q, addr_lo_q;
  logic [OFF_W-1:0] ptr_q, end_off_q;
  logic [15:0]      addr;
  logic             in_blk, known, rx_ok;

  assign addr   = {rx_byte_i, addr_lo_q};
  assign in_blk = (addr & ~16'(PAGE_BYTES - 1)) == BLOCK_BASE;
  assign known  = rx_byte_i inside {FN_WRITE_SP, FN_READ_SP, FN_COMMIT, FN_RELOAD};
  assign rx_ok  = rx_valid_i && !bus_reset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CMD;
      cmd_q     <= '0;
      addr_lo_q <= '0;
      ptr_q     <= '0;
      end_off_q <= '0;
    end else if (bus_reset_i) begin
      state_q <= ST_CMD;
    end else begin
      case (state_q)
        ST_CMD: if (rx_valid_i) begin
          cmd_q   <= rx_byte_i;
          state_q <= known ? ST_ADL : ST_SINK;
        end
        ST_ADL: if (rx_valid_i) begin
          addr_lo_q <= rx_byte_i;
          state_q   <= ST_ADH;
        end
        ST_ADH: if (rx_valid_i) begin
          ptr_q <= addr[OFF_W-1:0];
          if (!in_blk) state_q <= ST_SINK;
          else begin
            case (cmd_q)
              FN_WRITE_SP: state_q <= busy_i ? ST_SINK : ST_WR;
              FN_READ_SP:  state_q <= ST_RD;
              FN_COMMIT:   state_q <= ST_END;
              default:     state_q <= ST_SINK;
            endcase
          end
        end
        ST_WR: if (rx_valid_i) begin
          end_off_q <= ptr_q;
          ptr_q     <= ptr_q + 1'b1;
        end
        ST_RD: if (tx_req_i) ptr_q <= ptr_q + 1'b1;
        ST_END: if (rx_valid_i) state_q <= ST_SINK;
        default: ;
      endcase
    end
  end

  assign sp_we_o     = (state_q == ST_WR) && rx_ok;
  assign ptr_o       = ptr_q;
  assign rd_active_o = (state_q == ST_RD);
  assign reload_o    = (state_q == ST_ADH) && rx_ok && in_blk &&
                       (cmd_q == FN_RELOAD) && !busy_i;
  // confirming byte must equal the last written offset, upper bits zero
  assign commit_o    = (state_q == ST_END) && rx_ok && !busy_i &&
                       (rx_byte_i == 8'(end_off_q));
endmodule

// File: rtl/ow_mem_scratch.sv
module ow_mem_scratch #(
  parameter int  PAGE_BYTES = 32,
  localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [OFF_W-1:0]           waddr_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       load_i,
  input  logic [PAGE_BYTES-1:0][7:0] load_data_i,
  output logic [PAGE_BYTES-1:0][7:0] data_o
);
  logic [PAGE_BYTES-1:0][7:0] mem_q;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '0;
      else if (load_i)                         mem_q[i] <= load_data_i[i];
      else if (we_i && waddr_i == OFF_W'(i))   mem_q[i] <= wdata_i;
    end
  end

  assign data_o = mem_q;
endmodule

// File: rtl/ow_mem_nvm.sv
module ow_mem_nvm #(
  parameter int  PAGE_BYTES  = 32,
  parameter int  BUSY_CYCLES = 500000,
  localparam int CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [PAGE_BYTES-1:0][7:0] commit_data_i,
  output logic [PAGE_BYTES-1:0][7:0] data_o,
  output logic                       busy_o
);
  logic [PAGE_BYTES-1:0][7:0] mem_q;
  logic [CNT_W-1:0]           cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else if (commit_i) begin
      mem_q <= commit_data_i;
      cnt_q <= CNT_W'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign data_o = mem_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ow_mem_decoder.sv
module ow_mem_decoder #(
  parameter int          PAGE_BYTES  = 32,
  parameter int          BUSY_CYCLES = 500000,
  parameter logic [15:0] BLOCK_BASE  = 16'h0020
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_reset_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  input  logic       tx_req_i,
  output logic [7:0] tx_byte_o,
  output logic       busy_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic                       sp_we, rd_active, reload, commit;
  logic [OFF_W-1:0]           ptr;
  logic [PAGE_BYTES-1:0][7:0] sp_data, nv_data;

  ow_mem_fsm #(.PAGE_BYTES(PAGE_BYTES), .BLOCK_BASE(BLOCK_BASE)) u_fsm (
    .clk_i, .rst_ni, .bus_reset_i, .rx_valid_i, .rx_byte_i, .tx_req_i,
    .busy_i(busy_o), .sp_we_o(sp_we), .ptr_o(ptr), .rd_active_o(rd_active),
    .reload_o(reload), .commit_o(commit)
  );

  ow_mem_scratch #(.PAGE_BYTES(PAGE_BYTES)) u_scratch (
    .clk_i, .rst_ni, .we_i(sp_we), .waddr_i(ptr), .wdata_i(rx_byte_i),
    .load_i(reload), .load_data_i(nv_data), .data_o(sp_data)
  );

  ow_mem_nvm #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_nvm (
    .clk_i, .rst_ni, .commit_i(commit), .commit_data_i(sp_data),
    .data_o(nv_data), .busy_o
  );

  assign tx_byte_o = (rd_active && !busy_o) ? sp_data[ptr] : 8'hFF;
endmodule

// File: rtl/ow_mem_decoder_chk.sv
module ow_mem_decoder_chk #(
  parameter int BUSY_CYCLES = 500000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_reset_i,
  input logic       rx_valid_i,
  input logic       tx_req_i,
  input logic [7:0] tx_byte_o,
  input logic       busy_o
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  // R8
  bus_reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> tx_byte_o == 8'hFF);

  // R6
  busy_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> tx_byte_o == 8'hFF);

  // R4
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(rx_valid_i));

  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len == BUSY_CYCLES);

  // R3
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_req_i && !rx_valid_i && !bus_reset_i && !busy_o) |=> $stable(tx_byte_o));
endmodule

bind ow_mem_decoder ow_mem_decoder_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i, .rst_ni, .bus_reset_i, .rx_valid_i, .tx_req_i, .tx_byte_o, .busy_o
);

// File: tb/ow_mem_decoder_bench.sv
module ow_mem_decoder_bench;
  localparam int BUSY = 40;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_rst = 0, rx_valid = 0, tx_req = 0;
  logic [7:0] rx_byte = 0;
  logic [7:0] tx_byte;
  logic       busy;

  int checks = 0, errors = 0;
  logic [7:0] sp_m [32];
  logic [7:0] nv_m [32];

  always #5 clk = ~clk;

  ow_mem_decoder #(.BUSY_CYCLES(BUSY)) u_ow_mem_decoder (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_rst), .rx_valid_i(rx_valid),
    .rx_byte_i(rx_byte), .tx_req_i(tx_req), .tx_byte_o(tx_byte), .busy_o(busy)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic send(input logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic breset();
    bus_rst = 1;
    @(negedge clk);
    bus_rst = 0;
  endtask

  task automatic hdr(input logic [7:0] fn, input logic [7:0] lo, input logic [7:0] hi);
    breset();
    send(fn); send(lo); send(hi);
  endtask

  task automatic read_chk(input logic [7:0] exp, input string tag);
    chk(tx_byte, exp, tag);
    tx_req = 1;
    @(negedge clk);
    tx_req = 0;
  endtask

  task automatic read_page(input int start, input int n, input string tag);
    hdr(8'h69, 8'(8'h20 + start), 8'h00);
    for (int k = 0; k < n; k++) read_chk(sp_m[(start + k) % 32], tag);
  endtask

  task automatic reload_nv();
    hdr(8'hB8, 8'h20, 8'h00);
    for (int k = 0; k < 32; k++) sp_m[k] = nv_m[k];
  endtask

  initial begin
    for (int k = 0; k < 32; k++) begin sp_m[k] = 0; nv_m[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(tx_byte, 8'hFF, "R10 tx idle");
    chk(busy, 0, "R10 busy");
    reload_nv();
    read_page(0, 32, "R10 zero contents");

    // R2 R3 full write, read from every start with wrap
    hdr(8'h6C, 8'h20, 8'h00);
    for (int k = 0; k < 32; k++) begin
      sp_m[k] = 8'((k * 37 + 5) & 8'hFF);
      send(sp_m[k]);
    end
    for (int s = 0; s < 32; s++) read_page(s, 33, "R3 read wrap");

    // R2 write wrapping past offset 31
    hdr(8'h6C, 8'h3E, 8'h00);
    send(8'hA1); send(8'hA2); send(8'hA3);
    sp_m[30] = 8'hA1; sp_m[31] = 8'hA2; sp_m[0] = 8'hA3;
    read_page(28, 5, "R2 write wrap");

    // R5 mismatched confirm byte (last offset was 0)
    hdr(8'h48, 8'h3E, 8'h00);
    send(8'h05);
    chk(busy, 0, "R5 no busy");
    reload_nv();
    read_page(0, 32, "R5 nvm unchanged");

    // R4 good commit, measure busy window
    hdr(8'h6C, 8'h20, 8'h00);
    for (int k = 0; k < 32; k++) begin
      sp_m[k] = 8'(k ^ 8'h5A);
      send(sp_m[k]);
    end
    hdr(8'h48, 8'h20, 8'h00);
    send(8'h1F);
    for (int k = 0; k < 32; k++) nv_m[k] = sp_m[k];
    begin
      int n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(n, BUSY, "R4 busy length");
    end

    // R6 behaviour while busy
    hdr(8'h48, 8'h20, 8'h00);
    send(8'h1F);
    chk(busy, 1, "R4 second commit busy");
    hdr(8'h69, 8'h20, 8'h00);
    chk(tx_byte, 8'hFF, "R6 read while busy");
    hdr(8'h6C, 8'h20, 8'h00);
    send(8'h11);
    while (busy) @(negedge clk);
    read_page(0, 2, "R6 write ignored while busy");

    // R7 reload restores nonvolatile contents
    hdr(8'h6C, 8'h20, 8'h00);
    for (int k = 0; k < 32; k++) begin
      sp_m[k] = 8'hC0 + 8'(k);
      send(sp_m[k]);
    end
    reload_nv();
    read_page(0, 32, "R7 reload");

    // R8 bus reset during address and during write
    breset();
    send(8'h69); send(8'h25);
    hdr(8'h69, 8'h23, 8'h00);
    read_chk(sp_m[3], "R8 partial address dropped");
    hdr(8'h6C, 8'h20, 8'h00);
    send(8'h77);
    sp_m[0] = 8'h77;
    breset();
    chk(tx_byte, 8'hFF, "R8 tx after reset");
    send(8'h99);
    read_page(0, 2, "R8 write aborted");

    // R1 addresses outside the block
    hdr(8'h6C, 8'h40, 8'h00);
    send(8'h55);
    chk(tx_byte, 8'hFF, "R1 bad address tx");
    hdr(8'h6C, 8'h20, 8'h01);
    send(8'h56);
    hdr(8'h69, 8'h00, 8'h00);
    chk(tx_byte, 8'hFF, "R1 bad read address");
    read_page(0, 2, "R1 scratch unchanged");

    // R9 unknown function swallows following bytes
    breset();
    send(8'h33); send(8'h69); send(8'h20); send(8'h00);
    chk(tx_byte, 8'hFF, "R9 unknown code");
    read_page(0, 1, "R9 scratch unchanged");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule